// File: doc/BRIEF.md
# Conflict-Filled Instruction Cache

This block sits next to a program sequencer whose program memory has one port that serves both instruction fetches and data operands. When an instruction fetch and a data access to program memory fall in the same cycle, the port cannot serve both. The cache holds the instructions whose fetches have met such a collision. When the same instruction is fetched again under a collision, the cache supplies it, and the data access keeps the port. One instruction and two data operands then complete in a single cycle.

Fetches without a collision go straight to memory. They never allocate an entry, so the small store stays reserved for the instructions inside tight loops that also read coefficients from program memory. The store is direct-mapped and indexed by the low address bits. Each entry holds a tag and a valid flag.

A conflict miss costs one stall cycle. In the stall cycle the data access uses the port. In the following cycle the instruction word is read from memory, passed to the output and written into the cache. The sequencer must hold its fetch inputs while stall is high.

Top module: `sel_icache`

## Requirements
- R1: After reset, stall and hit are 0 and every entry is invalid, so the first conflicting fetch of any address misses.
- R2: A fetch with fetch_valid=1 and pm_conflict=0 gives instr_out=mem_instr in the same cycle, with stall=0 and hit=0.
- R3: A fetch without a conflict allocates nothing. A later conflicting fetch of the same address still misses.
- R4: A conflicting fetch that misses raises stall for exactly one cycle. In the next cycle stall is 0 and instr_out=mem_instr, and that word is stored for the held address.
- R5: A conflicting fetch whose address is stored raises hit and gives instr_out equal to the stored word in the same cycle, with stall=0, whatever mem_instr carries.
- R6: The index is fetch_addr[5:0], so 64 entries are addressed. Filling an address evicts any stored address that has the same low 6 bits.
- R7: A hit requires all 18 upper address bits (fetch_addr[23:6]) to match the stored tag. An address that differs from a stored one only in bit 23 misses.
- R8: With inval_all=1 at a clock edge, every entry becomes invalid. If this happens in a fill cycle, the invalidate wins and that fill is not kept.
- R9: pm_conflict is ignored in the fill cycle that follows a stall. That cycle has stall=0 and hit=0, and the fill completes.
- R10: With fetch_valid=0, stall and hit are 0, instr_out=mem_instr, and nothing is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval_all | input | 1 | Clear every valid flag at this edge |
| fetch_valid | input | 1 | Sequencer presents a fetch |
| fetch_addr | input | 24 | Instruction fetch address |
| pm_conflict | input | 1 | A data access to program memory falls in this cycle |
| mem_instr | input | 24 | Instruction word read from program memory |
| instr_out | output | 24 | Instruction delivered to the sequencer |
| stall | output | 1 | Hold the sequencer for this cycle |
| hit | output | 1 | Instruction served from the cache this cycle |

## Verification
The bench targets the aliasing cases that expose a wrong index or tag slice:
- Two addresses that share the low six bits must evict each other. A design that indexes wrongly would leave both resident.
- An address that differs only in its top bit must miss. A design that compares a truncated tag would report a false hit and return a stale word.

The bench also targets allocation on the wrong kind of fetch. A conflict-free fetch followed by a conflicting fetch of the same address must still stall. A design that fills on every miss would hit there instead.

Invalidation is exercised in the stall cycle and in the fill cycle:
- In the stall cycle, the fill must survive.
- In the fill cycle, the fill must be discarded.

A design that gets the priority between invalidate and fill wrong would later hit on that address, or miss on it. Long mixed runs over a small address pool compare stall, hit and the delivered word against a behavioural model on every cycle.

// File: rtl/sel_icache_pkg.sv
// Package: shared types of the conflict-filled instruction cache.
// Assumes: nothing beyond IEEE 1800-2017.
package sel_icache_pkg;
    // Controller phase: normal lookup, or the cycle that refills one entry.
    typedef enum logic {
        PH_LOOK = 1'b0,
        PH_FILL = 1'b1
    } fill_phase_e;
endpackage

// File: rtl/sel_icache_tags.sv
// Module: tag and valid store with the lookup comparator.
// Direct-mapped. The index is the low IDX_W address bits and the tag is the rest.
// Assumes: one write per cycle; invalidate-all has priority over the write.
module sel_icache_tags #(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_all,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              lookup_hit
);
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [IDX_W-1:0] rd_idx, wr_idx;

    assign rd_idx = rd_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];

    // One valid flag per entry: reset/invalidate clear it, a fill sets it.
    for (genvar e = 0; e < DEPTH; e++) begin : g_vld
        always_ff @(posedge clk) begin
            if (!rst_n || inval_all) begin
                vld[e] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                vld[e] <= 1'b1;
            end
        end
    end

    // Tag array write on fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_addr[ADDR_W-1:IDX_W];
        end
    end

    // Combinational lookup against the presented address.
    always_comb begin
        lookup_hit = vld[rd_idx] && (tag_mem[rd_idx] == rd_addr[ADDR_W-1:IDX_W]);
    end
endmodule

// File: rtl/sel_icache_data.sv
// Module: instruction word array, with an asynchronous read and a synchronous write.
// Assumes: validity is tracked by the tag store, so this array has no reset.
module sel_icache_data #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words [DEPTH];

    // Store the refilled instruction word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Read the word at the current fetch index.
    always_comb begin
        rd_data = words[rd_idx];
    end
endmodule

// File: rtl/sel_icache_ctrl.sv
// Module: fill controller.
// A conflicting miss stalls for one cycle and latches the address.
// The next cycle writes the memory word.
// Assumes: the sequencer holds its fetch while stall is high; pm_conflict is ignored in the fill cycle.
module sel_icache_ctrl
    import sel_icache_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              pm_conflict,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              lookup_hit,
    output logic              serve_hit,
    output logic              stall,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr
);
    fill_phase_e phase;
    logic        look_conf;

    // Decode this cycle's service from the phase and the lookup.
    always_comb begin
        look_conf = (phase == PH_LOOK) && fetch_valid && pm_conflict;
        serve_hit = look_conf && lookup_hit;
        stall     = look_conf && !lookup_hit;
        fill_en   = (phase == PH_FILL);
    end

    // Phase register: one fill cycle follows each stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOOK;
        end else begin
            phase <= stall ? PH_FILL : PH_LOOK;
        end
    end

    // Latch the missing address at the stall edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_addr <= '0;
        end else if (stall) begin
            fill_addr <= fetch_addr;
        end
    end
endmodule

// File: rtl/sel_icache.sv
// Module: top of the conflict-filled instruction cache.
// Serves an instruction from the cache only when the fetch collides with a data access to program memory and the entry is present.
// Otherwise the memory word passes through.
// Assumes: the memory returns mem_instr in the same cycle as the address.
module sel_icache #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_all,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              pm_conflict,
    input  logic [DATA_W-1:0] mem_instr,
    output logic [DATA_W-1:0] instr_out,
    output logic              stall,
    output logic              hit
);
    logic              lookup_hit;
    logic              serve_hit;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] cached_word;

    sel_icache_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .pm_conflict (pm_conflict),
        .fetch_addr  (fetch_addr),
        .lookup_hit  (lookup_hit),
        .serve_hit   (serve_hit),
        .stall       (stall),
        .fill_en     (fill_en),
        .fill_addr   (fill_addr)
    );

    sel_icache_tags #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval_all  (inval_all),
        .rd_addr    (fetch_addr),
        .wr_en      (fill_en),
        .wr_addr    (fill_addr),
        .lookup_hit (lookup_hit)
    );

    sel_icache_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
        .clk     (clk),
        .rd_idx  (fetch_addr[IDX_W-1:0]),
        .rd_data (cached_word),
        .wr_en   (fill_en),
        .wr_idx  (fill_addr[IDX_W-1:0]),
        .wr_data (mem_instr)
    );

    // Output select: the cached word on a served hit, the memory word otherwise.
    always_comb begin
        hit       = serve_hit;
        instr_out = serve_hit ? cached_word : mem_instr;
    end
endmodule

// File: rtl/sel_icache_chk.sv
// Module: protocol checker for sel_icache, attached through bind.
// Assumes: the sequencer holds its fetch inputs while stall is high.
module sel_icache_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              pm_conflict,
    input logic [DATA_W-1:0] mem_instr,
    input logic [DATA_W-1:0] instr_out,
    input logic              stall,
    input logic              hit
);
    AST_NO_CONFLICT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !pm_conflict) |-> (!stall && !hit && instr_out == mem_instr)); // R2
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R4
    AST_STALL_NEEDS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (fetch_valid && pm_conflict)); // R4
    AST_FILL_PASSES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!hit && instr_out == mem_instr)); // R9
    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!stall && fetch_valid && pm_conflict)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!stall && !hit && instr_out == mem_instr)); // R10
endmodule

bind sel_icache sel_icache_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .pm_conflict (pm_conflict),
    .mem_instr   (mem_instr),
    .instr_out   (instr_out),
    .stall       (stall),
    .hit         (hit)
);

// File: tb/tb_sel_icache.sv
module tb_sel_icache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval_all = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        pm_conflict = 1'b0;
    logic [23:0] mem_instr = '0;
    logic [23:0] instr_out;
    logic        stall, hit;

    int tests = 0;
    int fails = 0;

    // Behavioural model: full address -> stored word, plus a pending fill.
    logic [23:0] model [int];
    bit          pend = 1'b0;
    int          pend_addr = 0;

    always #2.5 clk = ~clk;

    sel_icache dut (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .pm_conflict(pm_conflict), .mem_instr(mem_instr),
        .instr_out(instr_out), .stall(stall), .hit(hit)
    );

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_insert(int a, logic [23:0] w);
        int victims[$];
        foreach (model[k]) if ((k & 63) == (a & 63)) victims.push_back(k);
        foreach (victims[i]) model.delete(victims[i]);
        model[a] = w;
    endtask

    // One cycle: drive at the falling edge, compare 1 ns later, then advance the model past the next rising edge.
    task automatic step(string tag, bit v, int a, bit c, int w, bit inv);
        bit          e_stall, e_hit, nx_pend;
        logic [23:0] e_out;
        @(negedge clk);
        fetch_valid = v; fetch_addr = 24'(a); pm_conflict = c;
        mem_instr = 24'(w); inval_all = inv;
        #1;
        e_stall = 0; e_hit = 0; e_out = 24'(w); nx_pend = 0;
        if (!pend && v && c) begin
            if (model.exists(a)) begin
                e_hit = 1; e_out = model[a];
            end else begin
                e_stall = 1; nx_pend = 1;
            end
        end
        check(tag, "stall", int'(stall), int'(e_stall));
        check(tag, "hit", int'(hit), int'(e_hit));
        check(tag, "instr_out", int'(instr_out), int'(e_out));
        if (inv) model.delete();
        else if (pend) model_insert(pend_addr, 24'(w));
        if (nx_pend) pend_addr = a;
        pend = nx_pend;
    endtask

    // Conflicting fetch that misses, then its fill cycle (conflict still raised, R9).
    task automatic fill(string tag, int a, int w);
        step(tag, 1, a, 1, 24'h0BAD00, 0);
        step(tag, 1, a, 1, w, 0);
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "stall in reset", int'(stall), 0);
        check("R1", "hit in reset", int'(hit), 0);
        rst_n = 1'b1;
        step("R10", 0, 24'h000105, 1, 24'h111111, 0);
        step("R2", 1, 24'h000105, 0, 24'h222222, 0);
        // R3: the earlier conflict-free fetch must not have allocated
        fill("R3", 24'h000105, 24'hA1A1A1);
        step("R5", 1, 24'h000105, 1, 24'h555555, 0);
        step("R2", 1, 24'h000105, 0, 24'h666666, 0);
        // R6: same index, different tag evicts
        fill("R6", 24'h000145, 24'hB2B2B2);
        step("R6", 1, 24'h000105, 1, 24'h777777, 0);
        step("R6", 1, 24'h000105, 1, 24'h777778, 0);
        step("R6", 1, 24'h000145, 1, 24'h777779, 0);
        // R7: differs only in bit 23
        fill("R7", 24'h000200, 24'hC3C3C3);
        step("R7", 1, 24'h800200, 1, 24'h888888, 0);
        step("R7", 1, 24'h800200, 1, 24'h999999, 0);
        // R8: invalidate in a lookup cycle, then in a stall cycle and in a fill cycle
        step("R8", 0, 0, 0, 0, 1);
        step("R8", 1, 24'h800200, 1, 24'h123456, 0);
        step("R8", 1, 24'h800200, 1, 24'h234567, 0);
        step("R8", 1, 24'h000300, 1, 24'h0, 1);
        step("R8", 1, 24'h000300, 1, 24'h345678, 0);
        step("R8", 1, 24'h000300, 1, 24'h0, 0);
        step("R8", 1, 24'h000301, 1, 24'h0, 0);
        step("R8", 1, 24'h000301, 1, 24'h456789, 1);
        step("R8", 1, 24'h000301, 1, 24'h0, 0);
        step("R8", 1, 24'h000301, 1, 24'h0, 0);
        // R10: idle cycles allocate nothing
        step("R10", 0, 24'h000377, 1, 24'h0, 0);
        step("R10", 1, 24'h000377, 1, 24'h0, 0);
        step("R10", 1, 24'h000377, 1, 24'h0, 0);
        // R6: fill all 64 indexes, then hit each one
        for (int i = 0; i < 64; i++) fill("R6", 24'h010000 + i, 24'h400000 + i * 3);
        for (int i = 0; i < 64; i++) step("R5", 1, 24'h010000 + i, 1, 24'hFFFFFF, 0);
        // Mixed run over a small aliasing pool
        for (int n = 0; n < 4000; n++) begin
            int a;
            bit v, c, inv;
            a   = ((int'($urandom_range(0, 3)) << 22) | int'($urandom_range(0, 7)) * 16 | (n & 1));
            v   = ($urandom_range(0, 9) != 0);
            c   = ($urandom_range(0, 2) != 0);
            inv = ($urandom_range(0, 199) == 0);
            if (pend) begin
                a = pend_addr;
                v = 1;
            end
            step("R5", v, a, c, int'($urandom_range(0, 24'hFFFFFF)), inv);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule